// File: doc/BRIEF.md
# Delay Slot Squash Controller

This block decides, for every resolved control transfer and every condition-carrying arithmetic result, whether the instruction sitting behind it in the pipeline is allowed to complete. The pipeline presents the already-resolved branch outcome together with a per-instruction slot policy. The block then raises a registered squash strobe toward the next stage one clock later. Four slot policies are supported:

- **Immediate:** no delay slot.
- **Delayed:** the slot always runs.
- **Annulling:** the slot runs only when the branch is taken.
- **Nullifying:** the outcome is weighed against the branch direction, which is found from the target and branch addresses.

A second path lets an arithmetic or logical instruction kill its successor when its result meets a selected condition. Branch resolution, target generation and fetch redirection sit elsewhere. The block only combines outcomes into the strobe.

Top module: `slot_squash_ctrl`

## Requirements
- R1: Policy code 0 (immediate): the successor is squashed when the branch is effectively taken (taken input high, or the unconditional flag high), and runs otherwise.
- R2: Policy code 1 (delayed): a branch never squashes its slot instruction, whether it is taken or not.
- R3: Policy code 2 (annulling): a conditional branch squashes its slot when not taken, and lets it run when taken.
- R4: Policy code 2 with the unconditional flag high always squashes the slot, whatever the taken input, so that the jump behaves as non-delayed.
- R5: Policy code 3 (nullifying): the slot runs for a forward branch that is not taken or a backward branch that is taken. It is squashed for a forward taken branch or a backward not-taken branch.
- R6: A branch counts as backward when its target is less than or equal to the branch address, compared unsigned. An equal target is backward.
- R7: A valid ALU result squashes the successor when its selected condition holds. The condition codes are: 0 never, 1 result zero, 2 result nonzero, 3 sign bit (MSB) set, 4 sign bit clear, 5 bit 0 set, 6 bit 0 clear, 7 always. The ALU request and the branch request are ORed.
- R8: The strobe appears on the clock edge after the request is presented and lasts one cycle per request. A stall presented with a request forces the strobe low for that request.
- R9: While reset is low the strobe is low, and asserting reset clears a pending strobe at once.
- R10: With neither the branch-valid nor the ALU-valid input high, the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Pipeline hold; suppresses a squash this cycle |
| br_valid | input | 1 | A resolved control transfer is presented |
| br_taken | input | 1 | Resolved outcome of the transfer |
| br_uncond | input | 1 | Transfer is unconditional (always taken) |
| br_mode | input | 2 | Slot policy: 0 immediate, 1 delayed, 2 annulling, 3 nullifying |
| br_target | input | AW | Transfer target address |
| br_pc | input | AW | Address of the transfer instruction |
| alu_valid | input | 1 | A condition-carrying ALU result is presented |
| alu_cond | input | 3 | Skip condition selector (see R7) |
| alu_result | input | DW | ALU result value |
| squash | output | 1 | Registered kill strobe for the following instruction |

## Verification
The properties assume that the outcome, policy and addresses are stable and meaningful only in cycles where the matching valid is high. They also assume that the stall applies to the same cycle as the request. The properties look only one edge ahead, so they do not care how long a request is held. The stimulus changes inputs only on the falling edge. It holds each request for exactly one rising edge and then either presents a fresh request or returns the valids low, so every expected strobe maps to one sampled request.

// File: rtl/squash_pkg.sv
package squash_pkg;

    typedef enum logic [1:0] {
        POL_IMMEDIATE = 2'd0,
        POL_DELAYED   = 2'd1,
        POL_ANNUL     = 2'd2,
        POL_NULLIFY   = 2'd3
    } slot_policy_e;

    typedef enum logic [2:0] {
        CND_NEVER   = 3'd0,
        CND_ZERO    = 3'd1,
        CND_NONZERO = 3'd2,
        CND_NEG     = 3'd3,
        CND_NONNEG  = 3'd4,
        CND_ODD     = 3'd5,
        CND_EVEN    = 3'd6,
        CND_ALWAYS  = 3'd7
    } skip_cond_e;

    typedef struct packed {
        logic squash;
    } squash_state_t;

endpackage

// File: rtl/squash_dir_cmp.sv
module squash_dir_cmp #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] pc,
    output logic          backward
);
    // Unsigned compare; an equal target points back at the branch itself.
    always_comb begin
        backward = (target <= pc);
    end
endmodule

// File: rtl/squash_branch_policy.sv
module squash_branch_policy
    import squash_pkg::*;
(
    input  logic         valid,
    input  logic         taken,
    input  logic         uncond,
    input  slot_policy_e policy,
    input  logic         backward,
    output logic         kill
);
    logic eff_taken;

    always_comb begin
        eff_taken = taken | uncond;
        kill      = 1'b0;
        if (valid) begin
            unique case (policy)
                POL_IMMEDIATE: kill = eff_taken;
                POL_DELAYED:   kill = 1'b0;
                POL_ANNUL:     kill = uncond | ~eff_taken;
                POL_NULLIFY:   kill = eff_taken ^ backward;
                default:       kill = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/squash_alu_cond.sv
module squash_alu_cond
    import squash_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          valid,
    input  skip_cond_e    cond,
    input  logic [DW-1:0] result,
    output logic          kill
);
    localparam int MSB = DW - 1;

    logic is_zero;
    logic hit;

    always_comb begin
        is_zero = (result == '0);
        unique case (cond)
            CND_NEVER:   hit = 1'b0;
            CND_ZERO:    hit = is_zero;
            CND_NONZERO: hit = ~is_zero;
            CND_NEG:     hit = result[MSB];
            CND_NONNEG:  hit = ~result[MSB];
            CND_ODD:     hit = result[0];
            CND_EVEN:    hit = ~result[0];
            CND_ALWAYS:  hit = 1'b1;
            default:     hit = 1'b0;
        endcase
        kill = valid & hit;
    end
endmodule

// File: rtl/slot_squash_ctrl.sv
module slot_squash_ctrl
    import squash_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          br_valid,
    input  logic          br_taken,
    input  logic          br_uncond,
    input  logic [1:0]    br_mode,
    input  logic [AW-1:0] br_target,
    input  logic [AW-1:0] br_pc,
    input  logic          alu_valid,
    input  logic [2:0]    alu_cond,
    input  logic [DW-1:0] alu_result,
    output logic          squash
);
    squash_state_t st_d, st_q;
    logic backward;
    logic br_kill;
    logic alu_kill;

    squash_dir_cmp #(.AW(AW)) u_dir (
        .target   (br_target),
        .pc       (br_pc),
        .backward (backward)
    );

    squash_branch_policy u_pol (
        .valid    (br_valid),
        .taken    (br_taken),
        .uncond   (br_uncond),
        .policy   (slot_policy_e'(br_mode)),
        .backward (backward),
        .kill     (br_kill)
    );

    squash_alu_cond #(.DW(DW)) u_alu (
        .valid  (alu_valid),
        .cond   (skip_cond_e'(alu_cond)),
        .result (alu_result),
        .kill   (alu_kill)
    );

    always_comb begin
        st_d        = st_q;
        st_d.squash = ~stall & (br_kill | alu_kill);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign squash = st_q.squash;
endmodule

// File: rtl/squash_chk.sv
module squash_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stall,
    input logic       br_valid,
    input logic       br_taken,
    input logic       br_uncond,
    input logic [1:0] br_mode,
    input logic       alu_valid,
    input logic [2:0] alu_cond,
    input logic       squash
);
    a_r1_immediate_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_mode == 2'd0 && (br_taken || br_uncond) && !stall) |=> squash);

    a_r2_delayed_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_mode == 2'd1 && !alu_valid) |=> !squash);

    a_r3_annul_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_mode == 2'd2 && !br_taken && !stall) |=> squash);

    a_r4_uncond_annul: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_mode == 2'd2 && br_uncond && !stall) |=> squash);

    a_r7_alu_always: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_cond == 3'd7 && !stall) |=> squash);

    a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !squash);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !alu_valid) |=> !squash);
endmodule

bind slot_squash_ctrl squash_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .br_valid  (br_valid),
    .br_taken  (br_taken),
    .br_uncond (br_uncond),
    .br_mode   (br_mode),
    .alu_valid (alu_valid),
    .alu_cond  (alu_cond),
    .squash    (squash)
);

// File: tb/sim_slot_squash_ctrl.sv
`timescale 1ns/1ps
module sim_slot_squash_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall = 1'b0;
    logic       br_valid = 1'b0;
    logic       br_taken = 1'b0;
    logic       br_uncond = 1'b0;
    logic [1:0] br_mode = 2'd0;
    logic [7:0] br_target = 8'd0;
    logic [7:0] br_pc = 8'd0;
    logic       alu_valid = 1'b0;
    logic [2:0] alu_cond = 3'd0;
    logic [7:0] alu_result = 8'd0;
    logic       squash;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    slot_squash_ctrl #(.AW(8), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .br_valid(br_valid), .br_taken(br_taken), .br_uncond(br_uncond),
        .br_mode(br_mode), .br_target(br_target), .br_pc(br_pc),
        .alu_valid(alu_valid), .alu_cond(alu_cond), .alu_result(alu_result),
        .squash(squash)
    );

    // {req[3:0], stall, bv, taken, uncond, mode[1:0], tgt[7:0], pc[7:0], av, cond[2:0], res[7:0], exp}
    localparam int NV = 27;
    localparam logic [38:0] VECS [0:NV-1] = '{
        {4'd1, 1'b0,1'b1,1'b1,1'b0,2'd0, 8'h40,8'h20, 1'b0,3'd0,8'h00, 1'b1}, // R1 taken
        {4'd1, 1'b0,1'b1,1'b0,1'b0,2'd0, 8'h40,8'h20, 1'b0,3'd0,8'h00, 1'b0}, // R1 not taken
        {4'd1, 1'b0,1'b1,1'b0,1'b1,2'd0, 8'h40,8'h20, 1'b0,3'd0,8'h00, 1'b1}, // R1 uncond
        {4'd2, 1'b0,1'b1,1'b1,1'b0,2'd1, 8'h40,8'h20, 1'b0,3'd0,8'h00, 1'b0}, // R2 taken
        {4'd2, 1'b0,1'b1,1'b0,1'b0,2'd1, 8'h10,8'h20, 1'b0,3'd0,8'h00, 1'b0}, // R2 not taken
        {4'd3, 1'b0,1'b1,1'b1,1'b0,2'd2, 8'h40,8'h20, 1'b0,3'd0,8'h00, 1'b0}, // R3 taken
        {4'd3, 1'b0,1'b1,1'b0,1'b0,2'd2, 8'h40,8'h20, 1'b0,3'd0,8'h00, 1'b1}, // R3 not taken
        {4'd4, 1'b0,1'b1,1'b1,1'b1,2'd2, 8'h40,8'h20, 1'b0,3'd0,8'h00, 1'b1}, // R4 uncond annul
        {4'd5, 1'b0,1'b1,1'b0,1'b0,2'd3, 8'h40,8'h20, 1'b0,3'd0,8'h00, 1'b0}, // R5 fwd not taken
        {4'd5, 1'b0,1'b1,1'b1,1'b0,2'd3, 8'h40,8'h20, 1'b0,3'd0,8'h00, 1'b1}, // R5 fwd taken
        {4'd5, 1'b0,1'b1,1'b1,1'b0,2'd3, 8'h10,8'h20, 1'b0,3'd0,8'h00, 1'b0}, // R5 bwd taken
        {4'd5, 1'b0,1'b1,1'b0,1'b0,2'd3, 8'h10,8'h20, 1'b0,3'd0,8'h00, 1'b1}, // R5 bwd not taken
        {4'd6, 1'b0,1'b1,1'b1,1'b0,2'd3, 8'h20,8'h20, 1'b0,3'd0,8'h00, 1'b0}, // R6 equal taken
        {4'd6, 1'b0,1'b1,1'b0,1'b0,2'd3, 8'h20,8'h20, 1'b0,3'd0,8'h00, 1'b1}, // R6 equal not taken
        {4'd6, 1'b0,1'b1,1'b1,1'b0,2'd3, 8'hF0,8'h10, 1'b0,3'd0,8'h00, 1'b1}, // R6 unsigned fwd
        {4'd7, 1'b0,1'b0,1'b0,1'b0,2'd0, 8'h00,8'h00, 1'b1,3'd1,8'h00, 1'b1}, // R7 zero hit
        {4'd7, 1'b0,1'b0,1'b0,1'b0,2'd0, 8'h00,8'h00, 1'b1,3'd1,8'h05, 1'b0}, // R7 zero miss
        {4'd7, 1'b0,1'b0,1'b0,1'b0,2'd0, 8'h00,8'h00, 1'b1,3'd2,8'h05, 1'b1}, // R7 nonzero
        {4'd7, 1'b0,1'b0,1'b0,1'b0,2'd0, 8'h00,8'h00, 1'b1,3'd3,8'h80, 1'b1}, // R7 negative
        {4'd7, 1'b0,1'b0,1'b0,1'b0,2'd0, 8'h00,8'h00, 1'b1,3'd4,8'h80, 1'b0}, // R7 nonneg miss
        {4'd7, 1'b0,1'b0,1'b0,1'b0,2'd0, 8'h00,8'h00, 1'b1,3'd5,8'h03, 1'b1}, // R7 odd
        {4'd7, 1'b0,1'b0,1'b0,1'b0,2'd0, 8'h00,8'h00, 1'b1,3'd6,8'h03, 1'b0}, // R7 even miss
        {4'd7, 1'b0,1'b0,1'b0,1'b0,2'd0, 8'h00,8'h00, 1'b1,3'd0,8'h00, 1'b0}, // R7 never
        {4'd7, 1'b0,1'b0,1'b0,1'b0,2'd0, 8'h00,8'h00, 1'b1,3'd7,8'h00, 1'b1}, // R7 always
        {4'd8, 1'b1,1'b1,1'b1,1'b0,2'd0, 8'h40,8'h20, 1'b1,3'd7,8'h00, 1'b0}, // R8 stall
        {4'd10,1'b0,1'b0,1'b1,1'b1,2'd0, 8'h40,8'h20, 1'b0,3'd7,8'h00, 1'b0}, // R10 idle
        {4'd7, 1'b0,1'b1,1'b1,1'b0,2'd1, 8'h40,8'h20, 1'b1,3'd7,8'h00, 1'b1}  // R7 OR with delayed
    };

    function automatic string rname(input int n);
        case (n)
            1: return "R1";   2: return "R2";  3: return "R3";
            4: return "R4";   5: return "R5";  6: return "R6";
            7: return "R7";   8: return "R8";  9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic exp);
        checks++;
        if (squash !== exp) begin
            fails++;
            $display("FAIL %s: squash=%b expected=%b at %0t", req, squash, exp, $time);
        end
    endtask

    task automatic idle();
        stall = 1'b0; br_valid = 1'b0; alu_valid = 1'b0;
        br_taken = 1'b0; br_uncond = 1'b0;
    endtask

    task automatic present(input logic [38:0] v);
        stall      = v[34];
        br_valid   = v[33];
        br_taken   = v[32];
        br_uncond  = v[31];
        br_mode    = v[30:29];
        br_target  = v[28:21];
        br_pc      = v[20:13];
        alu_valid  = v[12];
        alu_cond   = v[11:9];
        alu_result = v[8:1];
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        // R9: strobe low while reset held, even with a squashing request
        @(negedge clk);
        present(VECS[0]);
        @(negedge clk);
        check("R9", 1'b0);
        @(negedge clk);
        check("R9", 1'b0);
        idle();
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", 1'b0);

        for (int i = 0; i < NV; i++) begin
            present(VECS[i]);
            @(negedge clk);
            check(rname(int'(VECS[i][38:35])), VECS[i][0]);
        end

        // R8: one request gives exactly one strobe cycle
        idle();
        @(negedge clk);
        br_valid = 1'b1; br_mode = 2'd0; br_taken = 1'b1;
        @(negedge clk);
        check("R8", 1'b1);
        idle();
        @(negedge clk);
        check("R8", 1'b0);
        @(negedge clk);
        check("R10", 1'b0);

        // R8: stall on the request cycle only; following request still squashes
        alu_valid = 1'b1; alu_cond = 3'd7; stall = 1'b1;
        @(negedge clk);
        check("R8", 1'b0);
        stall = 1'b0;
        @(negedge clk);
        check("R8", 1'b1);
        idle();

        // R9: reset clears a pending strobe immediately
        br_valid = 1'b1; br_mode = 2'd2; br_taken = 1'b0;
        @(negedge clk);
        check("R9", 1'b1);
        rst_n = 1'b0;
        #1;
        check("R9", 1'b0);
        idle();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule